// File: doc/BRIEF.md
# Bunch-Train Timing Sequencer

This block drives the front-end timing for one bunch train from a single fast master clock running at sixteen ticks per bunch. A start command launches the train. For every bunch the block produces a sample-and-hold strobe once, plus a gain-range strobe and an ADC sample strobe four times. Once per train it also produces a single calibration pulse at a programmed bunch and tick. Each strobe sits at a phase, counted in master ticks, that software programs through a small register port.

A bunch counter steps through a programmable number of bunches, up to 4096. After the last tick of the last bunch, the block raises a one-cycle end-of-train pulse and returns to idle, so that readout can begin. The current bunch number and a train-active flag are visible at the ports throughout the train.

Top module: `train_timing_seq`

## Requirements
- R1: While reset is asserted and after its release, all strobes, `train_end` and `train_active` are low and `bunch_idx` is zero.
- R2: A `start_train` sampled high while idle makes `train_active` high in the next cycle, with `bunch_idx` = 0 and the tick counter at 0.
- R3: Configuration address 0 holds the last bunch index L in bits [11:0]. A train then lasts (L+1)*16 cycles, and `bunch_idx` advances by one every 16 cycles.
- R4: `train_end` is high for exactly one cycle: the cycle after the final tick of bunch L. `train_active` is low in that cycle.
- R5: A `start_train` sampled while a train is active, including on its final tick, has no effect on the counters or on the train length.
- R6: `sh_strobe` is high once per bunch, on the tick equal to the phase at address 1, bits [3:0].
- R7: `gain_strobe` is high on every tick t where t mod 4 equals the address 2 phase mod 4. That gives four strobes per bunch.
- R8: `adc_strobe` follows the same four-per-bunch rule as R7, using the phase at address 3.
- R9: `cal_pulse` is high for one tick only: when the bunch equals address 4 bits [11:0] and the tick equals address 5 bits [3:0]. If that bunch lies beyond L, there is no pulse.
- R10: While idle, no strobe and no calibration pulse is issued.
- R11: A `start_train` sampled in the `train_end` cycle is accepted and starts a new train.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 16 ticks per bunch |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 12 | Configuration write data |
| start_train | input | 1 | Start-of-train command |
| sh_strobe | output | 1 | Sample-and-hold strobe, once per bunch |
| gain_strobe | output | 1 | Gain-range strobe, four per bunch |
| adc_strobe | output | 1 | ADC sample strobe, four per bunch |
| cal_pulse | output | 1 | Single calibration pulse |
| bunch_idx | output | 12 | Current bunch number |
| train_active | output | 1 | High while a train runs |
| train_end | output | 1 | One-cycle end-of-train pulse |

## Verification
The sharpest collision is a start command arriving on the final tick of the last bunch. In that cycle the counter is about to end the train, and the start must be ignored. The bench aims a start at exactly that tick and at the `train_end` cycle that follows it. It expects the first start to be dropped and the second to open a fresh train at bunch zero.

A second overlap is the calibration pulse landing on the same tick as the sample-and-hold strobe and the train's last tick. The bench provokes it with a one-bunch train whose phases are all 15, and compares every output against its behavioural model on every cycle.

// File: rtl/ts_pkg.sv
package ts_pkg;
  localparam int CFG_AW = 3;

  typedef enum logic [CFG_AW-1:0] {
    CFG_LEN       = 3'd0,
    CFG_PH_SH     = 3'd1,
    CFG_PH_GAIN   = 3'd2,
    CFG_PH_ADC    = 3'd3,
    CFG_CAL_BUNCH = 3'd4,
    CFG_CAL_TICK  = 3'd5
  } cfg_addr_e;

  localparam int NUM_STROBES = 3;
  localparam int STB_SH      = 0;
  localparam int STB_GAIN    = 1;
  localparam int STB_ADC     = 2;
endpackage

// File: rtl/ts_cfg_regs.sv
module ts_cfg_regs
  import ts_pkg::*;
#(
  parameter int TICK_W  = 4,
  parameter int BUNCH_W = 12
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                we,
  input  logic [CFG_AW-1:0]                   addr,
  input  logic [BUNCH_W-1:0]                  wdata,
  output logic [BUNCH_W-1:0]                  len_m1,
  output logic [NUM_STROBES-1:0][TICK_W-1:0]  phase,
  output logic [BUNCH_W-1:0]                  cal_bunch,
  output logic [TICK_W-1:0]                   cal_tick
);

  logic len_en, calb_en, calt_en;

  always_comb begin
    len_en  = we && (addr == CFG_LEN);
    calb_en = we && (addr == CFG_CAL_BUNCH);
    calt_en = we && (addr == CFG_CAL_TICK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_m1 <= '0;
    end else if (len_en) begin
      len_m1 <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_bunch <= '0;
    end else if (calb_en) begin
      cal_bunch <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_tick <= '0;
    end else if (calt_en) begin
      cal_tick <= wdata[TICK_W-1:0];
    end
  end

  for (genvar gi = 0; gi < NUM_STROBES; gi++) begin : g_phase
    localparam logic [CFG_AW-1:0] ADDR_I = CFG_AW'(int'(CFG_PH_SH) + gi);
    logic ph_en;

    always_comb ph_en = we && (addr == ADDR_I);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        phase[gi] <= '0;
      end else if (ph_en) begin
        phase[gi] <= wdata[TICK_W-1:0];
      end
    end
  end

endmodule

// File: rtl/ts_train_ctrl.sv
module ts_train_ctrl #(
  parameter int TICK_W  = 4,
  parameter int BUNCH_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [BUNCH_W-1:0] len_m1,
  output logic               active,
  output logic [TICK_W-1:0]  tick,
  output logic [BUNCH_W-1:0] bunch,
  output logic               train_end
);

  localparam logic [TICK_W-1:0] TICK_MAX = '1;

  logic               act_q, act_d;
  logic [TICK_W-1:0]  tick_q, tick_d;
  logic [BUNCH_W-1:0] bunch_q, bunch_d;
  logic               end_q, end_d;
  logic               state_en;
  logic               last_tick;

  always_comb begin
    last_tick = (tick_q == TICK_MAX);
    state_en  = act_q | start;
    act_d     = act_q;
    tick_d    = tick_q;
    bunch_d   = bunch_q;
    end_d     = 1'b0;
    if (act_q) begin
      if (last_tick) begin
        tick_d = '0;
        if (bunch_q == len_m1) begin
          act_d = 1'b0;
          end_d = 1'b1;
        end else begin
          bunch_d = bunch_q + 1'b1;
        end
      end else begin
        tick_d = tick_q + 1'b1;
      end
    end else if (start) begin
      act_d   = 1'b1;
      tick_d  = '0;
      bunch_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      tick_q  <= '0;
      bunch_q <= '0;
    end else if (state_en) begin
      act_q   <= act_d;
      tick_q  <= tick_d;
      bunch_q <= bunch_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      end_q <= 1'b0;
    end else begin
      end_q <= end_d;
    end
  end

  assign active    = act_q;
  assign tick      = tick_q;
  assign bunch     = bunch_q;
  assign train_end = end_q;

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q && start) |=> (act_q && tick_q == '0 && bunch_q == '0)); // R2

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && start && tick_q != TICK_MAX) |=> (act_q && tick_q == $past(tick_q) + 1'b1)); // R5

  AST_END_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    end_q |=> !end_q); // R4

  AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    end_q |-> !act_q); // R4

endmodule

// File: rtl/ts_strobe_gen.sv
module ts_strobe_gen #(
  parameter int TICK_W = 4,
  parameter int PERIOD = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [TICK_W-1:0] tick,
  input  logic [TICK_W-1:0] phase,
  output logic              strobe
);

  localparam int PW = $clog2(PERIOD);

  logic [TICK_W-1:0] diff;

  always_comb begin
    diff   = tick - phase;
    strobe = active && (diff[PW-1:0] == '0);
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !strobe); // R10

  AST_STROBE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (!strobe || !$stable(phase))); // R7

endmodule

// File: rtl/ts_cal_match.sv
module ts_cal_match #(
  parameter int TICK_W  = 4,
  parameter int BUNCH_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic [TICK_W-1:0]  tick,
  input  logic [BUNCH_W-1:0] bunch,
  input  logic [BUNCH_W-1:0] cal_bunch,
  input  logic [TICK_W-1:0]  cal_tick,
  output logic               pulse
);

  logic bunch_hit, tick_hit;

  always_comb begin
    bunch_hit = (bunch == cal_bunch);
    tick_hit  = (tick == cal_tick);
    pulse     = active && bunch_hit && tick_hit;
  end

  AST_CAL_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> (!pulse || !$stable(cal_tick) || !$stable(cal_bunch))); // R9

  AST_CAL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !pulse); // R10

endmodule

// File: rtl/train_timing_seq.sv
module train_timing_seq
  import ts_pkg::*;
#(
  parameter int TICK_W        = 4,
  parameter int BUNCH_W       = 12,
  parameter int SUB_PER_BUNCH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_addr,
  input  logic [BUNCH_W-1:0] cfg_wdata,
  input  logic               start_train,
  output logic               sh_strobe,
  output logic               gain_strobe,
  output logic               adc_strobe,
  output logic               cal_pulse,
  output logic [BUNCH_W-1:0] bunch_idx,
  output logic               train_active,
  output logic               train_end
);

  localparam int TICKS_PER_BUNCH = 2 ** TICK_W;
  localparam int SUB_PERIOD      = TICKS_PER_BUNCH / SUB_PER_BUNCH;

  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync[1];

  logic [BUNCH_W-1:0]                 len_m1;
  logic [NUM_STROBES-1:0][TICK_W-1:0] phase;
  logic [BUNCH_W-1:0]                 cal_bunch;
  logic [TICK_W-1:0]                  cal_tick;
  logic                               active;
  logic [TICK_W-1:0]                  tick;
  logic [BUNCH_W-1:0]                 bunch;
  logic [NUM_STROBES-1:0]             strb;

  ts_cfg_regs #(.TICK_W(TICK_W), .BUNCH_W(BUNCH_W)) cfg_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .we        (cfg_we),
    .addr      (cfg_addr),
    .wdata     (cfg_wdata),
    .len_m1    (len_m1),
    .phase     (phase),
    .cal_bunch (cal_bunch),
    .cal_tick  (cal_tick)
  );

  ts_train_ctrl #(.TICK_W(TICK_W), .BUNCH_W(BUNCH_W)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (start_train),
    .len_m1    (len_m1),
    .active    (active),
    .tick      (tick),
    .bunch     (bunch),
    .train_end (train_end)
  );

  for (genvar gi = 0; gi < NUM_STROBES; gi++) begin : g_strobe
    localparam int P = (gi == STB_SH) ? TICKS_PER_BUNCH : SUB_PERIOD;
    ts_strobe_gen #(.TICK_W(TICK_W), .PERIOD(P)) stb_i (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .active (active),
      .tick   (tick),
      .phase  (phase[gi]),
      .strobe (strb[gi])
    );
  end

  ts_cal_match #(.TICK_W(TICK_W), .BUNCH_W(BUNCH_W)) cal_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .active    (active),
    .tick      (tick),
    .bunch     (bunch),
    .cal_bunch (cal_bunch),
    .cal_tick  (cal_tick),
    .pulse     (cal_pulse)
  );

  assign sh_strobe    = strb[STB_SH];
  assign gain_strobe  = strb[STB_GAIN];
  assign adc_strobe   = strb[STB_ADC];
  assign bunch_idx    = bunch;
  assign train_active = active;

  AST_SH_ONCE_PER_BUNCH: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sh_strobe && $stable(phase[STB_SH])) |=> !sh_strobe); // R6

  AST_IDLE_ZERO_STROBES: assert property (@(posedge clk) disable iff (!rst_int_n)
    !train_active |-> (strb == '0 && !cal_pulse)); // R10

endmodule

// File: tb/train_timing_seq_tb_top.sv
module train_timing_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [11:0] cfg_wdata;
  logic        start_train;
  logic        sh_strobe, gain_strobe, adc_strobe, cal_pulse;
  logic [11:0] bunch_idx;
  logic        train_active, train_end;

  always #10 clk = ~clk;

  train_timing_seq dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_addr     (cfg_addr),
    .cfg_wdata    (cfg_wdata),
    .start_train  (start_train),
    .sh_strobe    (sh_strobe),
    .gain_strobe  (gain_strobe),
    .adc_strobe   (adc_strobe),
    .cal_pulse    (cal_pulse),
    .bunch_idx    (bunch_idx),
    .train_active (train_active),
    .train_end    (train_end)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // behavioural reference model
  int r_act = 0, r_tick = 0, r_bunch = 0, r_end = 0;
  int c_len = 0, c_calb = 0, c_calt = 0;
  int c_ph[3] = '{0, 0, 0};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_act = 0; r_tick = 0; r_bunch = 0; r_end = 0;
      c_len = 0; c_calb = 0; c_calt = 0;
      c_ph[0] = 0; c_ph[1] = 0; c_ph[2] = 0;
    end else begin
      r_end = 0;
      if (r_act != 0) begin
        if (r_tick == 15) begin
          r_tick = 0;
          if (r_bunch == c_len) begin
            r_act = 0;
            r_end = 1;
          end else begin
            r_bunch = r_bunch + 1;
          end
        end else begin
          r_tick = r_tick + 1;
        end
      end else if (start_train) begin
        r_act = 1; r_tick = 0; r_bunch = 0;
      end
      if (cfg_we) begin
        case (cfg_addr)
          3'd0: c_len  = int'(cfg_wdata);
          3'd1: c_ph[0] = int'(cfg_wdata[3:0]);
          3'd2: c_ph[1] = int'(cfg_wdata[3:0]);
          3'd3: c_ph[2] = int'(cfg_wdata[3:0]);
          3'd4: c_calb = int'(cfg_wdata);
          3'd5: c_calt = int'(cfg_wdata[3:0]);
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      int e_sh, e_gn, e_ad, e_cal;
      e_sh  = (r_act != 0 && r_tick == c_ph[0]) ? 1 : 0;
      e_gn  = (r_act != 0 && (r_tick % 4) == (c_ph[1] % 4)) ? 1 : 0;
      e_ad  = (r_act != 0 && (r_tick % 4) == (c_ph[2] % 4)) ? 1 : 0;
      e_cal = (r_act != 0 && r_bunch == c_calb && r_tick == c_calt) ? 1 : 0;
      chk("R3", "train_active", int'(train_active), r_act);
      chk("R3", "bunch_idx", int'(bunch_idx), r_bunch);
      chk("R4", "train_end", int'(train_end), r_end);
      chk("R6", "sh_strobe", int'(sh_strobe), e_sh);
      chk("R7", "gain_strobe", int'(gain_strobe), e_gn);
      chk("R8", "adc_strobe", int'(adc_strobe), e_ad);
      chk("R9", "cal_pulse", int'(cal_pulse), e_cal);
      if (r_act == 0)
        chk("R10", "idle strobes", int'({sh_strobe, gain_strobe, adc_strobe, cal_pulse}), 0);
    end
  end

  task automatic wr(input int a, input int d);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 12'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_start();
    start_train = 1'b1;
    @(negedge clk);
    start_train = 1'b0;
  endtask

  task automatic wait_end();
    do @(negedge clk); while (r_end == 0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; start_train = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "outputs in reset",
        int'({sh_strobe, gain_strobe, adc_strobe, cal_pulse, train_active, train_end}), 0);
    chk("R1", "bunch_idx in reset", int'(bunch_idx), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "idle after reset", int'(train_active), 0);

    // basic train: 3 bunches, distinct phases
    wr(0, 2); wr(1, 3); wr(2, 1); wr(3, 6); wr(4, 1); wr(5, 5);
    pulse_start();
    chk("R2", "active after start", int'(train_active), 1);
    chk("R2", "bunch zero after start", int'(bunch_idx), 0);
    wait_end();
    chk("R4", "end pulse", int'(train_end), 1);
    chk("R4", "inactive at end", int'(train_active), 0);
    @(negedge clk);

    // start while active, at mid-train and at the final tick
    pulse_start();
    repeat (20) @(negedge clk);
    pulse_start();
    chk("R5", "start ignored mid-train bunch", int'(bunch_idx), 1);
    chk("R5", "still active", int'(train_active), 1);
    while (!(r_act != 0 && r_tick == 15 && r_bunch == c_len)) @(negedge clk);
    pulse_start();
    chk("R5", "start on last tick ignored, end", int'(train_end), 1);
    chk("R5", "start on last tick ignored, idle", int'(train_active), 0);
    pulse_start();
    chk("R11", "start in end cycle accepted", int'(train_active), 1);
    chk("R11", "restart bunch zero", int'(bunch_idx), 0);
    wait_end();
    @(negedge clk);

    // one-bunch train: cal, sh and last tick coincide
    wr(0, 0); wr(1, 15); wr(2, 15); wr(3, 15); wr(4, 0); wr(5, 15);
    pulse_start();
    repeat (15) @(negedge clk);
    chk("R9", "cal on last tick", int'(cal_pulse), 1);
    chk("R6", "sh on last tick", int'(sh_strobe), 1);
    @(negedge clk);
    chk("R4", "one-bunch end", int'(train_end), 1);

    // cal bunch beyond train length: no pulse
    wr(0, 2); wr(4, 9); wr(5, 0); wr(2, 2); wr(3, 0);
    pulse_start();
    wait_end();
    @(negedge clk);

    // maximum length train
    wr(0, 4095); wr(1, 0); wr(2, 2); wr(3, 1); wr(4, 4095); wr(5, 0);
    pulse_start();
    while (!(r_act != 0 && r_tick == 15 && r_bunch == 4095)) @(negedge clk);
    chk("R3", "last bunch index", int'(bunch_idx), 4095);
    wait_end();
    chk("R3", "max train ended", int'(train_active), 0);
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule